// File: doc/BRIEF.md
# Tape Status Word Reporter

This block holds the status state that a cartridge tape controller reports to its host. It is built around a 16-bit sticky status word split into two bytes. Each byte has a summary bit in its top position. That summary bit is rebuilt on every update from the seven detail bits below it, so the host can test a single bit to learn whether any condition in that byte is set. Two 16-bit counters sit beside the word: one for data errors and one for underruns. Other logic decides their values and loads them here; this block only stores and reports them.

The controller changes the word with set and clear mask strobes and with four event inputs. These are a read-error event, a controller reset, a cartridge check sampled together with the cartridge-present and writable levels, and the completion of a status readout.

A read-status command starts a readout. Each handshake step from the host then advances it by one byte and presents the next byte on a registered output. Advancing past the last byte ends the command, pulses a done flag and clears every status condition that does not describe the cartridge or its position. The host therefore sees transient conditions exactly once.

Top module: `tape_stat_reporter`

## Requirements
- R1: After synchronous reset the status word and both counters are zero, `data_out` is 0x00, `done` is 0 and no readout is active.
- R2: Bit 15 of the status word always equals the OR of bits 14..8 after any update; a set or clear mask bit at position 15 has no effect of its own.
- R3: Bit 7 of the status word always equals the OR of bits 6..0 after any update; a set or clear mask bit at position 7 has no effect of its own.
- R4: A `set_stb` cycle ORs `set_mask` into the detail bits and a `clr_stb` cycle clears the `clr_mask` bits; when both name the same bit in one cycle, the bit ends up set.
- R5: A `read_err` cycle sets bits 10 (unrecoverable data error), 9 (bad block not located) and 5 (no data) together.
- R6: A `ctl_reset` cycle with `cart_present` high sets bits 0 (power-on/reset) and 3 (beginning of media); with `cart_present` low it changes nothing.
- R7: A `cart_check` cycle replaces the whole word: with a cartridge it leaves only bit 3, plus bit 12 (write protected) when `cart_writable` is low; with no cartridge it leaves only bit 14 (no cartridge). In that cycle every other status update is ignored.
- R8: `err_load` and `urun_load` load `err_val` and `urun_val` into the error and underrun counters, which keep their value otherwise.
- R9: After `rs_start`, the first six `byte_adv` cycles put, one cycle later on `data_out`, the status high byte, status low byte, error counter high, error counter low, underrun counter high and underrun counter low, in that order, sampled in the advance cycle.
- R10: The seventh `byte_adv` of a readout returns the byte index to zero, ends the readout, leaves `data_out` unchanged and raises `done` for exactly one cycle.
- R11: The cycle that ends a readout clears every detail bit except 14, 13, 12, 11 and 3, and the summaries are then recomputed. Sets made in that same cycle still take effect.
- R12: A `byte_adv` with no readout active leaves `data_out` and `done` unchanged. An `rs_start` during a readout restarts it from the status high byte, and `rs_start` takes priority over a `byte_adv` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_stb | input | 1 | Apply `set_mask` this cycle |
| set_mask | input | 16 | Status bits to set |
| clr_stb | input | 1 | Apply `clr_mask` this cycle |
| clr_mask | input | 16 | Status bits to clear |
| read_err | input | 1 | Read-error event |
| ctl_reset | input | 1 | Controller reset event |
| cart_check | input | 1 | Cartridge check event |
| cart_present | input | 1 | Cartridge is in place |
| cart_writable | input | 1 | Cartridge accepts writes |
| err_load | input | 1 | Load the data-error counter |
| err_val | input | 16 | Value for the data-error counter |
| urun_load | input | 1 | Load the underrun counter |
| urun_val | input | 16 | Value for the underrun counter |
| rs_start | input | 1 | Begin a read-status readout |
| byte_adv | input | 1 | Host handshake step: advance one byte |
| data_out | output | 8 | Byte currently presented to the host |
| done | output | 1 | One-cycle pulse when a readout completes |

## Verification
On every cycle the assertions check that both summary bits agree with their detail bits and that the byte index stays in range. They also check that `done` is a single-cycle pulse that only follows a final advance, that a completion with no simultaneous set leaves only cartridge and position bits, and that a start or an idle advance has the required effect on the index and the output. Only the bench scenarios can show that each event sets its particular bits, that a cartridge check overrides other updates, that the six bytes arrive in the required order with the right values, and that counters loaded at arbitrary times are reported exactly.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  localparam int BYTE_W = 8;

  // Bit positions in the status word that the host decodes.
  localparam int B_SUM_HI = 15;
  localparam int B_SUM_LO = 7;

  // Masks of the status word.
  localparam logic [15:0] M_NOCART  = 16'h4000;  // bit 14
  localparam logic [15:0] M_WPROT   = 16'h1000;  // bit 12
  localparam logic [15:0] M_BOM     = 16'h0008;  // bit 3
  localparam logic [15:0] M_RDERR   = 16'h0620;  // bits 10, 9, 5
  localparam logic [15:0] M_PORBOM  = 16'h0009;  // bits 3, 0
  localparam logic [15:0] M_KEEP    = 16'h7808;  // bits 14..11, 3
  localparam logic [15:0] M_DETAIL  = 16'h7F7F;

endpackage

// File: rtl/tsr_status_reg.sv
module tsr_status_reg
  import tsr_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_stb,
  input  logic [SW-1:0] set_mask,
  input  logic          clr_stb,
  input  logic [SW-1:0] clr_mask,
  input  logic          read_err,
  input  logic          ctl_reset,
  input  logic          cart_check,
  input  logic          cart_present,
  input  logic          cart_writable,
  input  logic          fin_clear,
  output logic [SW-1:0] word
);

  localparam int NHALF = SW / BYTE_W;

  logic [SW-1:0]    raw_next;
  logic [SW-1:0]    word_next;
  logic [NHALF-1:0] summ;

  // Detail-bit update, summaries excluded until the fold below.
  always_comb begin
    raw_next = word;
    if (cart_check) begin
      if (cart_present) begin
        raw_next = cart_writable ? M_BOM : (M_BOM | M_WPROT);
      end else begin
        raw_next = M_NOCART;
      end
    end else begin
      if (fin_clear)                 raw_next = raw_next & M_KEEP;
      if (clr_stb)                   raw_next = raw_next & ~clr_mask;
      if (set_stb)                   raw_next = raw_next | set_mask;
      if (read_err)                  raw_next = raw_next | M_RDERR;
      if (ctl_reset && cart_present) raw_next = raw_next | M_PORBOM;
    end
  end

  // Each byte's top bit summarises the seven below it.
  for (genvar g = 0; g < NHALF; g++) begin : g_fold
    assign summ[g] = |raw_next[g*BYTE_W +: BYTE_W-1];
    assign word_next[g*BYTE_W +: BYTE_W-1] = raw_next[g*BYTE_W +: BYTE_W-1];
    assign word_next[g*BYTE_W + BYTE_W-1]  = summ[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else begin
      word <= word_next;
    end
  end

endmodule

// File: rtl/tsr_counters.sv
module tsr_counters #(
  parameter int W = 16,
  parameter int N = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        load,
  input  logic [N-1:0][W-1:0] val,
  output logic [N-1:0][W-1:0] cnt
);

  for (genvar i = 0; i < N; i++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt[i] <= '0;
      end else if (load[i]) begin
        cnt[i] <= val[i];
      end
    end
  end

endmodule

// File: rtl/tsr_readout.sv
module tsr_readout
  import tsr_pkg::*;
#(
  parameter int SEQ_W = 48,
  parameter int NSEQ  = SEQ_W / BYTE_W,
  parameter int IW    = $clog2(NSEQ + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rs_start,
  input  logic              byte_adv,
  input  logic [SEQ_W-1:0]  seq_vec,
  output logic [BYTE_W-1:0] data_out,
  output logic              done,
  output logic [IW-1:0]     idx,
  output logic              active,
  output logic              fin_clear
);

  localparam int            NSLOT = 2 ** IW;
  localparam logic [IW-1:0] LAST  = IW'(NSEQ);

  logic [BYTE_W-1:0] slot [NSLOT];

  // First byte of the sequence comes from the top of the vector.
  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    if (k < NSEQ) begin : g_used
      assign slot[k] = seq_vec[SEQ_W-1-k*BYTE_W -: BYTE_W];
    end else begin : g_pad
      assign slot[k] = '0;
    end
  end

  assign fin_clear = byte_adv && active && !rs_start && (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      active   <= 1'b0;
      data_out <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rs_start) begin
        idx    <= '0;
        active <= 1'b1;
      end else if (byte_adv && active) begin
        if (idx == LAST) begin
          idx    <= '0;
          active <= 1'b0;
          done   <= 1'b1;
        end else begin
          data_out <= slot[idx];
          idx      <= idx + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tape_stat_reporter.sv
module tape_stat_reporter
  import tsr_pkg::*;
#(
  parameter int STAT_W = 16,
  parameter int CNT_W  = 16,
  parameter int NCNT   = 2,
  parameter int SEQ_W  = STAT_W + NCNT * CNT_W,
  parameter int NSEQ   = SEQ_W / BYTE_W,
  parameter int IW     = $clog2(NSEQ + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_stb,
  input  logic [STAT_W-1:0] set_mask,
  input  logic              clr_stb,
  input  logic [STAT_W-1:0] clr_mask,
  input  logic              read_err,
  input  logic              ctl_reset,
  input  logic              cart_check,
  input  logic              cart_present,
  input  logic              cart_writable,
  input  logic              err_load,
  input  logic [CNT_W-1:0]  err_val,
  input  logic              urun_load,
  input  logic [CNT_W-1:0]  urun_val,
  input  logic              rs_start,
  input  logic              byte_adv,
  output logic [BYTE_W-1:0] data_out,
  output logic              done
);

  logic [STAT_W-1:0]           stat_word;
  logic [NCNT-1:0][CNT_W-1:0]  cnt_q;
  logic [NCNT-1:0][CNT_W-1:0]  cnt_val;
  logic [NCNT-1:0]             cnt_load;
  logic [NCNT*CNT_W-1:0]       cnt_flat;
  logic [SEQ_W-1:0]            seq_vec;
  logic [IW-1:0]               rd_idx;
  logic                        rd_active;
  logic                        fin_clear;

  assign cnt_load = {urun_load, err_load};
  assign cnt_val  = {urun_val, err_val};

  // Counter 0 (errors) is reported before counter 1 (underruns).
  for (genvar i = 0; i < NCNT; i++) begin : g_flat
    assign cnt_flat[(NCNT-1-i)*CNT_W +: CNT_W] = cnt_q[i];
  end
  assign seq_vec = {stat_word, cnt_flat};

  tsr_status_reg #(.SW(STAT_W)) u_status (
    .clk           (clk),
    .rst           (rst),
    .set_stb       (set_stb),
    .set_mask      (set_mask),
    .clr_stb       (clr_stb),
    .clr_mask      (clr_mask),
    .read_err      (read_err),
    .ctl_reset     (ctl_reset),
    .cart_check    (cart_check),
    .cart_present  (cart_present),
    .cart_writable (cart_writable),
    .fin_clear     (fin_clear),
    .word          (stat_word)
  );

  tsr_counters #(.W(CNT_W), .N(NCNT)) u_cnt (
    .clk  (clk),
    .rst  (rst),
    .load (cnt_load),
    .val  (cnt_val),
    .cnt  (cnt_q)
  );

  tsr_readout #(.SEQ_W(SEQ_W), .NSEQ(NSEQ), .IW(IW)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rs_start  (rs_start),
    .byte_adv  (byte_adv),
    .seq_vec   (seq_vec),
    .data_out  (data_out),
    .done      (done),
    .idx       (rd_idx),
    .active    (rd_active),
    .fin_clear (fin_clear)
  );

endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int IW   = 3,
  parameter int NSEQ = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [15:0]   word,
  input logic [IW-1:0] idx,
  input logic          active,
  input logic          done,
  input logic          byte_adv,
  input logic          rs_start,
  input logic [7:0]    data_out,
  input logic          set_stb,
  input logic          read_err,
  input logic          ctl_reset,
  input logic          cart_check
);

  localparam logic [IW-1:0] LAST    = IW'(NSEQ);
  localparam logic [15:0]   GONE    = 16'h0777;  // detail bits dropped at completion

  assert_hi_summary_R2: assert property (@(posedge clk) disable iff (rst)
    word[15] == (|word[14:8]));

  assert_lo_summary_R3: assert property (@(posedge clk) disable iff (rst)
    word[7] == (|word[6:0]));

  assert_idx_range_R10: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_cause_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(byte_adv && active && !rs_start && idx == LAST));

  assert_end_clear_R11: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(set_stb || read_err || ctl_reset || cart_check))
      |-> ((word & GONE) == 16'h0000));

  assert_start_idx_R12: assert property (@(posedge clk) disable iff (rst)
    rs_start |=> (idx == '0 && active));

  assert_idle_adv_R12: assert property (@(posedge clk) disable iff (rst)
    (byte_adv && !active && !rs_start) |=> ($stable(data_out) && !done));

endmodule

bind tape_stat_reporter tsr_checker #(.IW(IW), .NSEQ(NSEQ)) u_tsr_chk (
  .clk        (clk),
  .rst        (rst),
  .word       (stat_word),
  .idx        (rd_idx),
  .active     (rd_active),
  .done       (done),
  .byte_adv   (byte_adv),
  .rs_start   (rs_start),
  .data_out   (data_out),
  .set_stb    (set_stb),
  .read_err   (read_err),
  .ctl_reset  (ctl_reset),
  .cart_check (cart_check)
);

// File: tb/tb_tape_stat_reporter.sv
`timescale 1ns/1ps
module tb_tape_stat_reporter;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        set_stb = 0, clr_stb = 0, read_err = 0, ctl_reset = 0, cart_check = 0;
  logic [15:0] set_mask = 0, clr_mask = 0;
  logic        cart_present = 0, cart_writable = 0;
  logic        err_load = 0, urun_load = 0;
  logic [15:0] err_val = 0, urun_val = 0;
  logic        rs_start = 0, byte_adv = 0;
  logic [7:0]  data_out;
  logic        done;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  // Reference state
  logic [15:0] m_word = 0, m_err = 0, m_urun = 0;
  int          m_idx = 0;
  logic        m_act = 0;
  logic [7:0]  m_data = 0;
  logic        m_done = 0;

  always #10 clk = ~clk;

  tape_stat_reporter dut (
    .clk(clk), .rst(rst),
    .set_stb(set_stb), .set_mask(set_mask), .clr_stb(clr_stb), .clr_mask(clr_mask),
    .read_err(read_err), .ctl_reset(ctl_reset), .cart_check(cart_check),
    .cart_present(cart_present), .cart_writable(cart_writable),
    .err_load(err_load), .err_val(err_val), .urun_load(urun_load), .urun_val(urun_val),
    .rs_start(rs_start), .byte_adv(byte_adv),
    .data_out(data_out), .done(done)
  );

  function automatic logic [15:0] summ(input logic [15:0] w);
    logic [15:0] r = w;
    r[15] = |w[14:8];
    r[7]  = |w[6:0];
    return r;
  endfunction

  function automatic logic [7:0] pick(input logic [47:0] v, input int k);
    return v[47-8*k -: 8];
  endfunction

  task automatic check(input string req, input logic [47:0] got, input logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // One clock: predict, step, compare, release pulses.
  task automatic tick();
    logic [15:0] nw, ne, nu;
    int          ni;
    logic        na, ndn;
    logic [7:0]  nd;
    logic        fin;
    string       tag;
    nw = m_word; ne = m_err; nu = m_urun; ni = m_idx; na = m_act; nd = m_data; ndn = 1'b0;
    tag = "R9";
    if (rst) begin
      nw = 0; ne = 0; nu = 0; ni = 0; na = 0; nd = 0; tag = "R1";
    end else begin
      fin = byte_adv && m_act && !rs_start && (m_idx == 6);
      if (cart_check) begin
        nw = cart_present ? (cart_writable ? 16'h0008 : 16'h1008) : 16'h4000;
      end else begin
        if (fin) nw &= 16'h7808;
        if (clr_stb) nw &= ~clr_mask;
        if (set_stb) nw |= set_mask;
        if (read_err) nw |= 16'h0620;
        if (ctl_reset && cart_present) nw |= 16'h0009;
      end
      nw = summ(nw);
      if (err_load) ne = err_val;
      if (urun_load) nu = urun_val;
      if (rs_start) begin
        ni = 0; na = 1;
        if (byte_adv) tag = "R12";
      end else if (byte_adv && m_act) begin
        if (m_idx == 6) begin
          ni = 0; na = 0; ndn = 1; tag = "R10";
        end else begin
          nd = pick({m_word, m_err, m_urun}, m_idx);
          ni = m_idx + 1;
        end
      end else if (byte_adv) begin
        tag = "R12";
      end
    end
    @(posedge clk);
    #2;
    m_word = nw; m_err = ne; m_urun = nu; m_idx = ni; m_act = na; m_data = nd; m_done = ndn;
    check({tag, "_data"}, {40'd0, data_out}, {40'd0, m_data});
    check({tag, "_done"}, {47'd0, done}, {47'd0, m_done});
    set_stb = 0; clr_stb = 0; read_err = 0; ctl_reset = 0; cart_check = 0;
    err_load = 0; urun_load = 0; rs_start = 0; byte_adv = 0;
  endtask

  task automatic read_all(output logic [47:0] got);
    rs_start = 1; tick();
    for (int k = 0; k < 6; k++) begin
      byte_adv = 1; tick();
      got[47-8*k -: 8] = data_out;
    end
    byte_adv = 1; tick();
    check("R10_done_high", {47'd0, done}, 48'd1);
    tick();
    check("R10_done_low", {47'd0, done}, 48'd0);
  endtask

  task automatic read_word(output logic [15:0] w);
    logic [47:0] g;
    read_all(g);
    w = g[47:32];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [47:0] g;
    logic [15:0] w;
    void'($urandom(32'd20240611));
    rst = 1; tick(); tick(); tick();
    rst = 0; #1;
    check("R1_data", {40'd0, data_out}, 48'd0);
    check("R1_done", {47'd0, done}, 48'd0);
    read_all(g);
    check("R1_all_zero", g, 48'd0);

    // R2 R3: summary positions cannot be written
    set_stb = 1; set_mask = 16'h8080; tick();
    read_word(w); check("R2_R3_sum_write_ignored", {32'd0, w}, 48'd0);

    // R2: filemark raises high summary; R11 removes it
    set_stb = 1; set_mask = 16'h0100; tick();
    read_word(w); check("R2_hi_summary", {32'd0, w}, 48'h8100);
    read_word(w); check("R11_fm_cleared", {32'd0, w}, 48'd0);

    // R3: illegal command raises low summary
    set_stb = 1; set_mask = 16'h0040; tick();
    read_word(w); check("R3_lo_summary", {32'd0, w}, 48'h00C0);

    // R4: set beats clear on the same bit
    set_stb = 1; set_mask = 16'h0010; clr_stb = 1; clr_mask = 16'h0010; tick();
    read_word(w); check("R4_set_wins", {32'd0, w}, 48'h0090);
    set_stb = 1; set_mask = 16'h0800; tick();
    clr_stb = 1; clr_mask = 16'h0800; tick();
    read_word(w); check("R4_clear_drops_summary", {32'd0, w}, 48'd0);

    // R5
    read_err = 1; tick();
    read_word(w); check("R5_read_error", {32'd0, w}, 48'h86A0);

    // R6
    cart_present = 0; ctl_reset = 1; tick();
    read_word(w); check("R6_no_cart", {32'd0, w}, 48'd0);
    cart_present = 1; ctl_reset = 1; tick();
    read_word(w); check("R6_cart", {32'd0, w}, 48'h0089);
    read_word(w); check("R11_bom_kept", {32'd0, w}, 48'h0088);

    // R7
    set_stb = 1; set_mask = 16'h0300; tick();
    cart_check = 1; cart_present = 1; cart_writable = 1; tick();
    read_word(w); check("R7_writable", {32'd0, w}, 48'h0088);
    cart_check = 1; cart_writable = 0; tick();
    read_word(w); check("R7_protected", {32'd0, w}, 48'h9088);
    cart_check = 1; cart_present = 0; set_stb = 1; set_mask = 16'h0100; read_err = 1; tick();
    read_word(w); check("R7_no_cart_overrides", {32'd0, w}, 48'hC000);

    // R8 and R9 byte order
    err_load = 1; err_val = 16'hA55A; urun_load = 1; urun_val = 16'h1234; tick();
    read_all(g); check("R8_R9_order", g, 48'hC000_A55A_1234);

    // R11: full word then keep subset
    set_stb = 1; set_mask = 16'h7F7F; tick();
    read_word(w); check("R11_full", {32'd0, w}, 48'hFFFF);
    read_word(w); check("R11_keep", {32'd0, w}, 48'hF888);

    // R12: idle advance
    byte_adv = 1; tick();
    check("R12_idle_data", {40'd0, data_out}, {40'd0, 8'h34});
    check("R12_idle_done", {47'd0, done}, 48'd0);

    // R12: restart mid readout, start beats advance
    rs_start = 1; tick();
    for (int k = 0; k < 3; k++) begin byte_adv = 1; tick(); end
    rs_start = 1; byte_adv = 1; tick();
    byte_adv = 1; tick();
    check("R12_restart", {40'd0, data_out}, 48'hF8);
    for (int k = 0; k < 5; k++) begin byte_adv = 1; tick(); end
    // R11: set in the completion cycle survives
    byte_adv = 1; set_stb = 1; set_mask = 16'h0100; tick();
    check("R10_done_restart", {47'd0, done}, 48'd1);
    read_word(w); check("R11_set_on_finish", {32'd0, w}, 48'hF988);

    // Random phase against the reference state
    for (int n = 0; n < 6000; n++) begin
      if ($urandom_range(5) == 0) begin set_stb = 1; set_mask = 16'($urandom); end
      if ($urandom_range(5) == 0) begin clr_stb = 1; clr_mask = 16'($urandom); end
      if ($urandom_range(29) == 0) read_err = 1;
      if ($urandom_range(39) == 0) ctl_reset = 1;
      if ($urandom_range(59) == 0) cart_check = 1;
      if ($urandom_range(99) == 0) begin
        cart_present = 1'($urandom); cart_writable = 1'($urandom);
      end
      if ($urandom_range(39) == 0) begin err_load = 1; err_val = 16'($urandom); end
      if ($urandom_range(39) == 0) begin urun_load = 1; urun_val = 16'($urandom); end
      if (!m_act && $urandom_range(15) == 0) rs_start = 1;
      else if (m_act && $urandom_range(99) == 0) rs_start = 1;
      if ($urandom_range(2) == 0) byte_adv = 1;
      tick();
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule